// File: doc/BRIEF.md
# Double-Indexed DMA Address Generator

This block sequences the source and destination addresses for one DMA channel that moves a block made of frames, each frame holding a fixed number of elements. A start pulse captures the configuration: a 32-bit start address per side, given as two 16-bit halves; a control word that selects the element size, the request-sync granularity and an addressing mode per side; a signed element index and a signed frame index per side; and the element and frame counts. After that the channel is active. A sync request opens a grant worth one element, one frame or the rest of the block. Each element-advance strobe that arrives while a grant is open issues one element. In the next cycle the block shows the source and destination addresses of that element, together with end-of-frame and end-of-block flags.

The control word has these fields: bits 1:0 give the element size (00 one byte, 01 two bytes, 10 and 11 four bytes); bits 3:2 give the sync granularity (00 element, 01 frame, 10 and 11 block); bits 13:12 give the source addressing mode; bits 15:14 give the destination addressing mode. Both mode fields use the same encoding: 00 constant, 01 post-increment by the element size, 10 single-indexed, 11 double-indexed. Bus transactions, packing and arbitration are handled outside this block.

Top module: `dma_agen`

## Requirements
- R1: After reset, active_o, valid_o, frame_end_o and block_end_o are 0, and both address outputs are 0.
- R2: A start_i pulse sets active_o in the following cycle. The first element issued after a start carries, on each side, the address formed as {hi half, lo half} from that side's start inputs.
- R3: In mode 01, each issued element moves the address by the element size: 1, 2 or 4 bytes for size codes 00, 01 and 10.
- R4: In mode 00, every element of the block carries the start address.
- R5: In mode 10, every step adds (element bytes + element index − 1), frame boundaries included. The 16-bit index is signed and is sign-extended to 32 bits.
- R6: In mode 11, steps inside a frame add (element bytes + element index − 1). The step taken from the last element of a frame adds (element bytes + frame index − 1), with the frame index sign-extended.
- R7: The source follows control bits 13:12 and the destination follows bits 15:14, each with its own index pair. Neither side's setting affects the other.
- R8: frame_end_o is 1 with the last element of every frame. block_end_o is 1 only with the last element of the last frame, and active_o is 0 in that same cycle.
- R9: An advance strobe with no open grant, or with the channel inactive, issues nothing (valid_o stays 0).
- R10: In frame sync (bits 3:2 = 01), one request lets advances issue elements up to and including the next frame end. After that the grant closes.
- R11: In block sync (bits 3:2 = 10), one request covers every remaining element of the block.
- R12: A request that arrives while a grant is still open is ignored. In element sync, two requests followed by two advances issue exactly one element.
- R13: A start after the block has ended reloads the counters and both addresses from the configuration inputs.
- R14: An element count or frame count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture the configuration and begin a block |
| req_i | input | 1 | Sync request; opens a grant |
| adv_i | input | 1 | Element-advance strobe |
| ctrl_i | input | 16 | Control word (size, sync, source mode, destination mode) |
| src_start_hi_i | input | 16 | Source start address, upper half |
| src_start_lo_i | input | 16 | Source start address, lower half |
| dst_start_hi_i | input | 16 | Destination start address, upper half |
| dst_start_lo_i | input | 16 | Destination start address, lower half |
| src_eidx_i | input | 16 | Source element index, signed |
| src_fidx_i | input | 16 | Source frame index, signed |
| dst_eidx_i | input | 16 | Destination element index, signed |
| dst_fidx_i | input | 16 | Destination frame index, signed |
| elem_count_i | input | 16 | Elements per frame |
| frame_count_i | input | 16 | Frames per block |
| active_o | output | 1 | Channel is running a block |
| valid_o | output | 1 | An element was issued; addresses and flags are valid |
| src_addr_o | output | 32 | Source address of the issued element |
| dst_addr_o | output | 32 | Destination address of the issued element |
| frame_end_o | output | 1 | Issued element is the last of its frame |
| block_end_o | output | 1 | Issued element is the last of the block |

## Verification
The hardest case to reach from the ports is a request that arrives while a grant is still open, because at the ports it looks the same as a request that was accepted. The element-sync scenario sends two requests back to back and then counts how many advances actually produce an element. The frame-boundary step in double-indexed mode is driven with a negative frame index, so that the address goes backwards across a frame edge. The address is placed so that this step also carries through the upper half.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

    localparam int CTRL_W = 16;

    typedef enum logic [1:0] {
        AM_CONST   = 2'b00,
        AM_POSTINC = 2'b01,
        AM_SINGLE  = 2'b10,
        AM_DOUBLE  = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        SY_ELEM  = 2'b00,
        SY_FRAME = 2'b01,
        SY_BLOCK = 2'b10,
        SY_WHOLE = 2'b11
    } sync_e;

    // Control-word field positions; the two mode fields keep fixed slots.
    localparam int ESZ_LSB  = 0;
    localparam int SYNC_LSB = 2;
    localparam int SRCM_LSB = 12;
    localparam int DSTM_LSB = 14;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   size_bytes = 3'd1;
            2'b01:   size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_agen_side.sv
module dma_agen_side
    import dma_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              advance_i,
    input  logic              frame_last_i,
    input  amode_e            mode_i,
    input  logic [2:0]        ebytes_i,
    input  logic [IDX_W-1:0]  eidx_i,
    input  logic [IDX_W-1:0]  fidx_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int EXT_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } side_state_t;

    side_state_t st_d, st_q;

    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] eidx_w;
    logic [ADDR_W-1:0] fidx_w;
    logic [ADDR_W-1:0] step_w;

    always_comb begin
        base_w = {{(ADDR_W-3){1'b0}}, ebytes_i};
        eidx_w = {{EXT_W{eidx_i[IDX_W-1]}}, eidx_i};
        fidx_w = {{EXT_W{fidx_i[IDX_W-1]}}, fidx_i};
        case (mode_i)
            AM_CONST:   step_w = '0;
            AM_POSTINC: step_w = base_w;
            AM_SINGLE:  step_w = base_w + eidx_w - 1'b1;
            default:    step_w = frame_last_i ? (base_w + fidx_w - 1'b1)
                                              : (base_w + eidx_w - 1'b1);
        endcase

        st_d = st_q;
        if (load_i) begin
            st_d.addr = start_addr_i;
        end else if (advance_i) begin
            st_d.addr = st_q.addr + step_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

endmodule

// File: rtl/dma_agen_count.sv
module dma_agen_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             advance_i,
    input  logic [CNT_W-1:0] elem_count_i,
    input  logic [CNT_W-1:0] frame_count_i,
    output logic             frame_last_o,
    output logic             block_last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] elem;
        logic [CNT_W-1:0] frame;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic [CNT_W-1:0] elem_last_w;
    logic [CNT_W-1:0] frame_last_w;

    always_comb begin
        // A zero count is read as one.
        elem_last_w  = (elem_count_i  == '0) ? '0 : elem_count_i  - 1'b1;
        frame_last_w = (frame_count_i == '0) ? '0 : frame_count_i - 1'b1;

        frame_last_o = (st_q.elem == elem_last_w);
        block_last_o = frame_last_o && (st_q.frame == frame_last_w);

        st_d = st_q;
        if (load_i) begin
            st_d.elem  = '0;
            st_d.frame = '0;
        end else if (advance_i) begin
            if (frame_last_o) begin
                st_d.elem  = '0;
                st_d.frame = block_last_o ? '0 : st_q.frame + 1'b1;
            end else begin
                st_d.elem = st_q.elem + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dma_agen_sync.sv
module dma_agen_sync
    import dma_agen_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  active_i,
    input  logic  req_i,
    input  logic  issue_i,
    input  logic  frame_last_i,
    input  logic  block_last_i,
    input  sync_e mode_i,
    output logic  grant_o
);

    typedef struct packed {
        logic grant;
    } sync_state_t;

    sync_state_t st_d, st_q;

    logic close_w;

    always_comb begin
        case (mode_i)
            SY_ELEM:  close_w = issue_i;
            SY_FRAME: close_w = issue_i && frame_last_i;
            default:  close_w = issue_i && block_last_i;
        endcase

        st_d = st_q;
        if (load_i) begin
            st_d.grant = 1'b0;
        end else if (st_q.grant) begin
            // A request while a grant is open is dropped.
            if (close_w || (issue_i && block_last_i)) begin
                st_d.grant = 1'b0;
            end
        end else if (req_i && active_i) begin
            st_d.grant = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = st_q.grant;

endmodule

// File: rtl/dma_agen.sv
module dma_agen
    import dma_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              req_i,
    input  logic              adv_i,
    input  logic [15:0]       ctrl_i,
    input  logic [15:0]       src_start_hi_i,
    input  logic [15:0]       src_start_lo_i,
    input  logic [15:0]       dst_start_hi_i,
    input  logic [15:0]       dst_start_lo_i,
    input  logic [IDX_W-1:0]  src_eidx_i,
    input  logic [IDX_W-1:0]  src_fidx_i,
    input  logic [IDX_W-1:0]  dst_eidx_i,
    input  logic [IDX_W-1:0]  dst_fidx_i,
    input  logic [CNT_W-1:0]  elem_count_i,
    input  logic [CNT_W-1:0]  frame_count_i,
    output logic              active_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic              frame_end_o,
    output logic              block_end_o
);

    localparam int NSIDE = 2;
    localparam int HALF_W = ADDR_W / 2;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [IDX_W-1:0]  s_eidx;
        logic [IDX_W-1:0]  s_fidx;
        logic [IDX_W-1:0]  d_eidx;
        logic [IDX_W-1:0]  d_fidx;
        logic [CNT_W-1:0]  ecount;
        logic [CNT_W-1:0]  fcount;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic              active;
        logic              valid;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              feof;
        logic              feob;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              grant_w;
    logic              issue_w;
    logic              frame_last_w;
    logic              block_last_w;
    logic [2:0]        ebytes_w;
    sync_e             sync_w;
    logic [ADDR_W-1:0] side_start [NSIDE];
    logic [ADDR_W-1:0] side_addr  [NSIDE];
    amode_e            side_mode  [NSIDE];
    logic [IDX_W-1:0]  side_eidx  [NSIDE];
    logic [IDX_W-1:0]  side_fidx  [NSIDE];

    assign side_start[0] = {src_start_hi_i[HALF_W-1:0], src_start_lo_i[HALF_W-1:0]};
    assign side_start[1] = {dst_start_hi_i[HALF_W-1:0], dst_start_lo_i[HALF_W-1:0]};
    assign side_mode[0]  = amode_e'(st_q.cfg.ctrl[SRCM_LSB +: 2]);
    assign side_mode[1]  = amode_e'(st_q.cfg.ctrl[DSTM_LSB +: 2]);
    assign side_eidx[0]  = st_q.cfg.s_eidx;
    assign side_fidx[0]  = st_q.cfg.s_fidx;
    assign side_eidx[1]  = st_q.cfg.d_eidx;
    assign side_fidx[1]  = st_q.cfg.d_fidx;

    assign ebytes_w = size_bytes(st_q.cfg.ctrl[ESZ_LSB +: 2]);
    assign sync_w   = sync_e'(st_q.cfg.ctrl[SYNC_LSB +: 2]);
    assign issue_w  = st_q.active && grant_w && adv_i && !start_i;

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            dma_agen_side #(
                .ADDR_W (ADDR_W),
                .IDX_W  (IDX_W)
            ) u_side (
                .clk          (clk),
                .rst_n        (rst_n),
                .load_i       (start_i),
                .start_addr_i (side_start[s]),
                .advance_i    (issue_w),
                .frame_last_i (frame_last_w),
                .mode_i       (side_mode[s]),
                .ebytes_i     (ebytes_w),
                .eidx_i       (side_eidx[s]),
                .fidx_i       (side_fidx[s]),
                .addr_o       (side_addr[s])
            );
        end
    endgenerate

    dma_agen_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (start_i),
        .advance_i     (issue_w),
        .elem_count_i  (st_q.cfg.ecount),
        .frame_count_i (st_q.cfg.fcount),
        .frame_last_o  (frame_last_w),
        .block_last_o  (block_last_w)
    );

    dma_agen_sync u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (start_i),
        .active_i     (st_q.active),
        .req_i        (req_i),
        .issue_i      (issue_w),
        .frame_last_i (frame_last_w),
        .block_last_i (block_last_w),
        .mode_i       (sync_w),
        .grant_o      (grant_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.feof  = 1'b0;
        st_d.feob  = 1'b0;
        if (start_i) begin
            st_d.active     = 1'b1;
            st_d.cfg.ctrl   = ctrl_i;
            st_d.cfg.s_eidx = src_eidx_i;
            st_d.cfg.s_fidx = src_fidx_i;
            st_d.cfg.d_eidx = dst_eidx_i;
            st_d.cfg.d_fidx = dst_fidx_i;
            st_d.cfg.ecount = elem_count_i;
            st_d.cfg.fcount = frame_count_i;
        end else if (issue_w) begin
            st_d.valid = 1'b1;
            st_d.src   = side_addr[0];
            st_d.dst   = side_addr[1];
            st_d.feof  = frame_last_w;
            st_d.feob  = block_last_w;
            if (block_last_w) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o    = st_q.active;
    assign valid_o     = st_q.valid;
    assign src_addr_o  = st_q.src;
    assign dst_addr_o  = st_q.dst;
    assign frame_end_o = st_q.feof;
    assign block_end_o = st_q.feob;

endmodule

// File: rtl/dma_agen_chk.sv
module dma_agen_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic adv_i,
    input logic active_o,
    input logic valid_o,
    input logic frame_end_o,
    input logic block_end_o
);

    p_start_activates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);

    p_flag_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> valid_o);

    p_eob_has_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        block_end_o |-> frame_end_o);

    p_eob_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        block_end_o |-> !active_o);

    p_valid_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(active_o) && $past(adv_i)));

endmodule

bind dma_agen dma_agen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .adv_i       (adv_i),
    .active_o    (active_o),
    .valid_o     (valid_o),
    .frame_end_o (frame_end_o),
    .block_end_o (block_end_o)
);

// File: tb/dma_agen_test.sv
`timescale 1ns/1ps
module dma_agen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, req = 1'b0, adv = 1'b0;
    logic [15:0] ctrl = '0;
    logic [15:0] s_hi = '0, s_lo = '0, d_hi = '0, d_lo = '0;
    logic [15:0] s_ei = '0, s_fi = '0, d_ei = '0, d_fi = '0;
    logic [15:0] ecnt = '0, fcnt = '0;
    logic        active, valid, feof, feob;
    logic [31:0] src_a, dst_a;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench reference state
    logic [31:0] m_src, m_dst;
    int unsigned m_e, m_f;

    always #4 clk = ~clk;

    dma_agen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_i(req), .adv_i(adv),
        .ctrl_i(ctrl), .src_start_hi_i(s_hi), .src_start_lo_i(s_lo),
        .dst_start_hi_i(d_hi), .dst_start_lo_i(d_lo),
        .src_eidx_i(s_ei), .src_fidx_i(s_fi), .dst_eidx_i(d_ei), .dst_fidx_i(d_fi),
        .elem_count_i(ecnt), .frame_count_i(fcnt),
        .active_o(active), .valid_o(valid), .src_addr_o(src_a), .dst_addr_o(dst_a),
        .frame_end_o(feof), .block_end_o(feob)
    );

    function automatic logic [15:0] mk_ctrl(input logic [1:0] dm, input logic [1:0] sm,
                                            input logic [1:0] sy, input logic [1:0] sz);
        return {dm, sm, 8'h00, sy, sz};
    endfunction

    function automatic logic [31:0] bytes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] m,
                                        input logic [1:0] sz, input logic [15:0] ei,
                                        input logic [15:0] fi, input bit fend);
        logic [31:0] sei, sfi;
        sei = {{16{ei[15]}}, ei};
        sfi = {{16{fi[15]}}, fi};
        case (m)
            2'd0: return a;
            2'd1: return a + bytes_of(sz);
            2'd2: return a + bytes_of(sz) + sei - 32'd1;
            default: return fend ? a + bytes_of(sz) + sfi - 32'd1
                                 : a + bytes_of(sz) + sei - 32'd1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_start(input string tag);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        m_src = {s_hi, s_lo};
        m_dst = {d_hi, d_lo};
        m_e = 0;
        m_f = 0;
        check(active === 1'b1, tag, {127'd0, active}, 128'd1);
    endtask

    task automatic do_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic do_adv(input bit expect_issue, input string tag);
        int unsigned el, fl;
        bit fe, be;
        logic [67:0] act, exp;
        @(negedge clk) adv = 1'b1;
        @(negedge clk) adv = 1'b0;
        el = (ecnt == 0) ? 0 : ecnt - 1;
        fl = (fcnt == 0) ? 0 : fcnt - 1;
        fe = (m_e == el);
        be = fe && (m_f == fl);
        act = {1'b0, valid, feof, feob, src_a, dst_a};
        if (expect_issue) begin
            exp = {1'b0, 1'b1, fe, be, m_src, m_dst};
            check(act === exp, tag, {60'd0, act}, {60'd0, exp});
            m_src = nxt(m_src, ctrl[13:12], ctrl[1:0], s_ei, s_fi, fe);
            m_dst = nxt(m_dst, ctrl[15:14], ctrl[1:0], d_ei, d_fi, fe);
            if (fe) begin
                m_e = 0;
                m_f = be ? 0 : m_f + 1;
            end else begin
                m_e++;
            end
            if (be) check(active === 1'b0, {tag, " R8 idle"}, {127'd0, active}, 128'd0);
        end else begin
            check(valid === 1'b0, tag, {127'd0, valid}, 128'd0);
        end
    endtask

    task automatic t_reset();
        check({active, valid, feof, feob, src_a, dst_a} === '0, "R1 reset",
              {60'd0, active, valid, feof, feob, src_a, dst_a}, 128'd0);
    endtask

    // R3 / R11: post-increment on both sides, 16-bit, block sync
    task automatic t_postinc();
        ctrl = mk_ctrl(2'b01, 2'b01, 2'b10, 2'b01);
        s_hi = 16'h2000; s_lo = 16'hFFFC; d_hi = 16'h3000; d_lo = 16'h0100;
        ecnt = 16'd3; fcnt = 16'd2;
        do_start("R2 start");
        do_adv(1'b0, "R9 no grant");
        do_req();
        for (int i = 0; i < 6; i++) do_adv(1'b1, "R3 R11 postinc");
        do_adv(1'b0, "R8 after block end");
    endtask

    // R4 / R5 / R7: constant source, single-indexed destination with negative index
    task automatic t_const_single();
        ctrl = mk_ctrl(2'b10, 2'b00, 2'b10, 2'b00);
        s_hi = 16'h0000; s_lo = 16'h4444; d_hi = 16'h0001; d_lo = 16'h0010;
        d_ei = 16'hFFFE; d_fi = 16'h0100;
        ecnt = 16'd2; fcnt = 16'd3;
        do_start("R2 start");
        do_req();
        for (int i = 0; i < 6; i++) do_adv(1'b1, "R4 R5 R7 const single");
    endtask

    // R6 / R7: double-indexed source, negative frame index, 32-bit elements
    task automatic t_double();
        ctrl = mk_ctrl(2'b01, 2'b11, 2'b11, 2'b10);
        s_hi = 16'h1000; s_lo = 16'h0000; d_hi = 16'h0000; d_lo = 16'h0000;
        s_ei = 16'd5; s_fi = 16'hFFEC;
        ecnt = 16'd3; fcnt = 16'd2;
        do_start("R2 start");
        do_req();
        for (int i = 0; i < 6; i++) do_adv(1'b1, "R6 R7 double");
    endtask

    // R9 / R12: element sync
    task automatic t_elem_sync();
        ctrl = mk_ctrl(2'b01, 2'b01, 2'b00, 2'b00);
        s_hi = 16'h0000; s_lo = 16'h0800; d_hi = 16'h0000; d_lo = 16'h0900;
        ecnt = 16'd4; fcnt = 16'd1;
        do_start("R2 start");
        do_adv(1'b0, "R9 element no grant");
        do_req();
        do_req();
        do_adv(1'b1, "R12 element first");
        do_adv(1'b0, "R12 second request ignored");
        do_req();
        do_adv(1'b1, "R9 element second");
    endtask

    // R10: frame sync
    task automatic t_frame_sync();
        ctrl = mk_ctrl(2'b01, 2'b01, 2'b01, 2'b00);
        s_hi = 16'h0000; s_lo = 16'h0000; d_hi = 16'h0000; d_lo = 16'h0040;
        ecnt = 16'd3; fcnt = 16'd2;
        do_start("R2 start");
        do_req();
        for (int i = 0; i < 3; i++) do_adv(1'b1, "R10 frame one");
        do_adv(1'b0, "R10 grant closed");
        do_req();
        for (int i = 0; i < 3; i++) do_adv(1'b1, "R10 frame two");
    endtask

    // R13: restart after block end
    task automatic t_restart();
        ctrl = mk_ctrl(2'b01, 2'b01, 2'b10, 2'b10);
        s_hi = 16'h00AA; s_lo = 16'h0000; d_hi = 16'h00BB; d_lo = 16'h0000;
        ecnt = 16'd2; fcnt = 16'd1;
        do_start("R2 start");
        do_req();
        for (int i = 0; i < 2; i++) do_adv(1'b1, "R13 first pass");
        do_start("R13 restart active");
        do_req();
        for (int i = 0; i < 2; i++) do_adv(1'b1, "R13 reloaded");
    endtask

    // R14: zero counts
    task automatic t_zero_count();
        ctrl = mk_ctrl(2'b01, 2'b01, 2'b10, 2'b00);
        s_lo = 16'h0123; d_lo = 16'h0456;
        ecnt = 16'd0; fcnt = 16'd0;
        do_start("R2 start");
        do_req();
        do_adv(1'b1, "R14 zero count single element");
        do_adv(1'b0, "R14 no second element");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_postinc();
        t_const_single();
        t_double();
        t_elem_sync();
        t_frame_sync();
        t_restart();
        t_zero_count();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule